// File: doc/BRIEF.md
# Dual-Clock FIFO with Write-Reset Signalling

This block is a first-in first-out queue whose producer and consumer sit on clocks with no fixed relation. Data is stored in a RAM with one write port and one registered read port, so an FPGA block RAM can hold it. Each side keeps a binary pointer one bit wider than the RAM address and publishes it as a registered Gray code. The opposite domain samples that Gray code through two flops and converts it back to binary. Each side then subtracts the two pointers to get its own level and its own ready flag.

Reset is asymmetric. The write-domain reset is the only one that discards data. It is carried into the read domain by a two-flop reset bridge. The bridge output clears the read pointer and the read side's copy of the write pointer. The same bridge output also drives the read-reset indication port. A read-domain reset only silences the read outputs while it is held. When it is released, the stored entries reappear in their original order.

The capacity requested through a parameter is rounded up to a power of two. If exact capacity is demanded and the request is not a power of two, elaboration stops with an error.

Top module: `xclk_fifo`

## Requirements
- R1: Entries leave in the order they were accepted. While `r_rdy` is 1, `r_data` holds the oldest unread entry. After an accepted read, the next entry is on `r_data` in the following read cycle. Without a read, `r_data` holds its value.
- R2: A write strobe while `w_rdy` is 0 stores nothing, and `w_level` does not rise because of it.
- R3: A read strobe while `r_rdy` is 0 removes nothing. Entries written later still come out in full.
- R4: `w_level` is never below the number of entries truly stored, and never above the capacity. `w_rdy` is 0 exactly when `w_level` equals the capacity.
- R5: `r_level` is never above the number of entries truly stored. `r_rdy` is 1 exactly when `r_level` is non-zero.
- R6: With both strobes idle, `w_level` and `r_level` both equal the stored count within a few cycles of the slower clock.
- R7: After a write-domain reset, the queue is empty. Once both sides settle, both levels read 0, `r_rdy` reads 0 and `w_rdy` reads 1.
- R8: `r_rst_flag` is 1 for at least one read-clock cycle after each write-domain reset. That reset must be held for at least three read-clock cycles.
- R9: While `rrst` is held, `r_rdy` and `r_level` read 0 from the next read edge on. After release, every stored entry is still present, in its original order.
- R10: The capacity is `REQ_DEPTH` rounded up to a power of two, so a request of 6 holds 8 entries. With `EXACT_DEPTH` set, a request that is not a power of two is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write-side synchronous reset, active high; empties the queue |
| w_en | input | 1 | Write strobe |
| w_data | input | DW | Entry to store |
| w_rdy | output | 1 | Space available for a write |
| w_level | output | clog2(depth+1) | Unread entries as seen from the write side |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read-side synchronous reset, active high; keeps stored entries |
| r_en | input | 1 | Read strobe |
| r_data | output | DW | Oldest unread entry, valid while r_rdy is 1 |
| r_rdy | output | 1 | An entry is available |
| r_level | output | clog2(depth+1) | Unread entries as seen from the read side |
| r_rst_flag | output | 1 | High in the read domain after a write-side reset |

## Verification
The two functions that can meet in one cycle are an accepted write and an accepted read at the same pointer boundary. This happens when the queue is exactly full or exactly empty while both strobes are held. The bench first fills the queue to capacity. It then holds both strobes on their unrelated 5 ns and 7 ns clocks, so that refills land in the same cycles that drain the last free slot or the last entry. A behavioural queue model judges every read cycle's data. The level bounds of R4 and R5 are compared on every edge of each clock. A random phase repeats the collision under irregular strobe patterns.

// File: rtl/xq_pkg.sv
`timescale 1ns/1ps
package xq_pkg;

  // Smallest power of two that is not below n (n >= 1).
  function automatic int unsigned xq_pow2_ceil(input int unsigned n);
    int unsigned p;
    p = 1;
    for (int i = 0; i < 32; i++) begin
      if (p < n) p = p << 1;
    end
    return p;
  endfunction

endpackage

// File: rtl/xq_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray pointer; presents the result in binary.
module xq_ptr_sync #(
  parameter int unsigned PW = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stg1;
  logic [PW-1:0] stg2;

  always_ff @(posedge clk) begin
    if (clr) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= gray_in;
      stg2 <= stg1;
    end
  end

  // Gray to binary: each bit is the parity of all Gray bits at or above it.
  for (genvar i = 0; i < PW; i++) begin : g_g2b
    assign bin_out[i] = ^stg2[PW-1:i];
  end
endmodule

// File: rtl/xq_rst_bridge.sv
`timescale 1ns/1ps
// Carries the write-side reset into the read clock domain.
module xq_rst_bridge #(
  parameter int unsigned STAGES = 2
) (
  input  logic rclk,
  input  logic wrst,
  output logic rd_clr
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge rclk) begin
    shreg <= {shreg[STAGES-2:0], wrst};
  end

  assign rd_clr = shreg[STAGES-1];
endmodule

// File: rtl/xq_dpram.sv
`timescale 1ns/1ps
// Simple dual-port RAM: write on wclk, registered read on rclk.
module xq_dpram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xq_wr_ctrl.sv
`timescale 1ns/1ps
// Write-side pointer, level and ready logic.
module xq_wr_ctrl #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned PW    = 4
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          w_en,
  input  logic [PW-1:0] rd_bin,
  output logic          w_rdy,
  output logic [PW-1:0] w_level,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [PW-1:0] wr_gray
);
  logic [PW-1:0] wptr;
  logic [PW-1:0] wptr_nxt;
  logic [PW-1:0] lvl_nxt;

  assign wr_fire = w_en & w_rdy;
  assign wr_addr = wptr[AW-1:0];

  always_comb begin
    wptr_nxt = wptr + PW'(wr_fire);
    lvl_nxt  = wptr_nxt - rd_bin;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wptr    <= '0;
      wr_gray <= '0;
      w_rdy   <= 1'b0;
      w_level <= '0;
    end else begin
      wptr    <= wptr_nxt;
      wr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      w_rdy   <= (lvl_nxt != PW'(DEPTH));
      w_level <= lvl_nxt;
    end
  end
endmodule

// File: rtl/xq_rd_ctrl.sv
`timescale 1ns/1ps
// Read-side pointer, level and ready logic.
module xq_rd_ctrl #(
  parameter int unsigned AW = 3,
  parameter int unsigned PW = 4
) (
  input  logic          rclk,
  input  logic          rd_clr,
  input  logic          rrst,
  input  logic          r_en,
  input  logic [PW-1:0] wr_bin,
  output logic          r_rdy,
  output logic [PW-1:0] r_level,
  output logic [AW-1:0] rd_addr,
  output logic [PW-1:0] rd_gray
);
  logic [PW-1:0] rptr;
  logic [PW-1:0] rptr_nxt;
  logic [PW-1:0] lvl_nxt;
  logic          take;

  assign take = r_en & r_rdy & ~rrst;

  always_comb begin
    if (rd_clr) rptr_nxt = '0;
    else        rptr_nxt = rptr + PW'(take);
    lvl_nxt = wr_bin - rptr_nxt;
  end

  // The RAM is addressed with the next pointer, so its registered output
  // already holds the entry at the pointer once that pointer is current.
  assign rd_addr = rptr_nxt[AW-1:0];

  always_ff @(posedge rclk) begin
    rptr    <= rptr_nxt;
    rd_gray <= rptr_nxt ^ (rptr_nxt >> 1);
    if (rd_clr || rrst) begin
      r_rdy   <= 1'b0;
      r_level <= '0;
    end else begin
      r_rdy   <= (lvl_nxt != '0);
      r_level <= lvl_nxt;
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int unsigned DW          = 8,
  parameter int unsigned REQ_DEPTH   = 6,
  parameter bit          EXACT_DEPTH = 1'b0,
  localparam int unsigned DEPTH = xq_pkg::xq_pow2_ceil(REQ_DEPTH),
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          w_en,
  input  logic [DW-1:0] w_data,
  output logic          w_rdy,
  output logic [PW-1:0] w_level,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          r_en,
  output logic [DW-1:0] r_data,
  output logic          r_rdy,
  output logic [PW-1:0] r_level,
  output logic          r_rst_flag
);
  if (REQ_DEPTH < 2) begin : g_too_small
    $error("xclk_fifo: REQ_DEPTH must be at least 2");
  end
  if (EXACT_DEPTH && (DEPTH != REQ_DEPTH)) begin : g_not_pow2
    $error("xclk_fifo: exact depth requested but REQ_DEPTH is not a power of two");
  end

  logic          rd_clr;
  logic          wr_fire;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic [PW-1:0] wr_gray;
  logic [PW-1:0] rd_gray;
  logic [PW-1:0] wr_bin_s;
  logic [PW-1:0] rd_bin_s;

  xq_rst_bridge #(.STAGES(2)) u_bridge (
    .rclk   (rclk),
    .wrst   (wrst),
    .rd_clr (rd_clr)
  );

  assign r_rst_flag = rd_clr;

  xq_ptr_sync #(.PW(PW)) u_sync_r2w (
    .clk     (wclk),
    .clr     (wrst),
    .gray_in (rd_gray),
    .bin_out (rd_bin_s)
  );

  xq_ptr_sync #(.PW(PW)) u_sync_w2r (
    .clk     (rclk),
    .clr     (rd_clr),
    .gray_in (wr_gray),
    .bin_out (wr_bin_s)
  );

  xq_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .wclk    (wclk),
    .wrst    (wrst),
    .w_en    (w_en),
    .rd_bin  (rd_bin_s),
    .w_rdy   (w_rdy),
    .w_level (w_level),
    .wr_fire (wr_fire),
    .wr_addr (wr_addr),
    .wr_gray (wr_gray)
  );

  xq_rd_ctrl #(.AW(AW), .PW(PW)) u_rd (
    .rclk    (rclk),
    .rd_clr  (rd_clr),
    .rrst    (rrst),
    .r_en    (r_en),
    .wr_bin  (wr_bin_s),
    .r_rdy   (r_rdy),
    .r_level (r_level),
    .rd_addr (rd_addr),
    .rd_gray (rd_gray)
  );

  xq_dpram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (wr_fire),
    .waddr (wr_addr),
    .wdata (w_data),
    .rclk  (rclk),
    .raddr (rd_addr),
    .rdata (r_data)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned LW    = 4
) (
  input logic          wclk,
  input logic          wrst,
  input logic          w_en,
  input logic          w_rdy,
  input logic [LW-1:0] w_level,
  input logic          rclk,
  input logic          rrst,
  input logic          r_en,
  input logic [DW-1:0] r_data,
  input logic          r_rdy,
  input logic [LW-1:0] r_level,
  input logic          r_rst_flag
);
  // R2: a refused write never raises the write-side level
  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (wrst)
    (w_en && !w_rdy) |=> (w_level <= $past(w_level)));

  // R4: at capacity the write side refuses
  p_full_blocks_r4: assert property (@(posedge wclk) disable iff (wrst)
    (w_level == LW'(DEPTH)) |-> !w_rdy);

  // R4: level never exceeds capacity
  p_wlevel_max_r4: assert property (@(posedge wclk) disable iff (wrst)
    w_level <= LW'(DEPTH));

  // R5: ready and non-zero level agree
  p_rready_level_r5: assert property (@(posedge rclk) disable iff (rrst)
    r_rdy == (r_level != '0));

  // R5: read-side level never exceeds capacity
  p_rlevel_max_r5: assert property (@(posedge rclk) disable iff (rrst)
    r_level <= LW'(DEPTH));

  // R9: read-side reset silences the read outputs on the next edge
  p_rrst_quiet_r9: assert property (@(posedge rclk)
    rrst |=> (!r_rdy && r_level == '0));

  // R1: an entry not taken stays presented and unchanged
  p_rdata_hold_r1: assert property (@(posedge rclk) disable iff (rrst || r_rst_flag)
    (r_rdy && !r_en) |=> (r_rdy && $stable(r_data)));
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .LW(PW)) u_chk (
  .wclk       (wclk),
  .wrst       (wrst),
  .w_en       (w_en),
  .w_rdy      (w_rdy),
  .w_level    (w_level),
  .rclk       (rclk),
  .rrst       (rrst),
  .r_en       (r_en),
  .r_data     (r_data),
  .r_rdy      (r_rdy),
  .r_level    (r_level),
  .r_rst_flag (r_rst_flag)
);

// File: tb/xclk_fifo_test.sv
`timescale 1ns/1ps
module xclk_fifo_test;
  localparam int DW  = 8;
  localparam int REQ = 6;

  function automatic int round_up(input int n);
    int p;
    p = 1;
    while (p < n) p = p * 2;
    return p;
  endfunction

  localparam int CAP = round_up(REQ);
  localparam int LW  = $clog2(CAP + 1);

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          wrst, rrst, w_en, r_en;
  logic [DW-1:0] w_data;
  logic          w_rdy, r_rdy, r_rst_flag;
  logic [LW-1:0] w_level, r_level;
  logic [DW-1:0] r_data;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  xclk_fifo #(.DW(DW), .REQ_DEPTH(REQ), .EXACT_DEPTH(1'b0)) uut (
    .wclk(wclk), .wrst(wrst), .w_en(w_en), .w_data(w_data),
    .w_rdy(w_rdy), .w_level(w_level),
    .rclk(rclk), .rrst(rrst), .r_en(r_en), .r_data(r_data),
    .r_rdy(r_rdy), .r_level(r_level), .r_rst_flag(r_rst_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit flag_seen = 1'b0;
  bit rrst_prev = 1'b0;
  logic [DW-1:0] model [$];
  logic [DW-1:0] seq = 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Write-side reference: compare bounds, then log an accepted write.
  always @(negedge wclk) begin
    if (mon_on) begin
      chk(int'(w_level) >= model.size(), "R4", "w_level below occupancy",
          int'(w_level), model.size());
      chk((!w_rdy) == (int'(w_level) == CAP), "R4", "w_rdy vs level",
          int'(w_rdy), int'(int'(w_level) != CAP));
      if (w_en && w_rdy) model.push_back(w_data);
    end
  end

  // Read-side reference: bounds, data order, then log an accepted read.
  always @(negedge rclk) begin
    if (r_rst_flag) flag_seen = 1'b1;
    if (mon_on) begin
      chk(int'(r_level) <= model.size(), "R5", "r_level above occupancy",
          int'(r_level), model.size());
      chk(r_rdy == (r_level != '0), "R5", "r_rdy vs level",
          int'(r_rdy), int'(r_level != '0));
      if (rrst && rrst_prev)
        chk(!r_rdy && r_level == '0, "R9", "read outputs during rrst",
            int'(r_level), 0);
      if (r_rdy) begin
        if (model.size() == 0) chk(1'b0, "R1", "data with empty model", int'(r_data), -1);
        else chk(r_data == model[0], "R1", "r_data order", int'(r_data), int'(model[0]));
      end
      if (r_en && r_rdy && !rrst) void'(model.pop_front());
    end
    rrst_prev = rrst;
  end

  task automatic settle();
    repeat (14) @(posedge rclk);
    @(negedge rclk);
  endtask

  task automatic put(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge wclk); #1;
      w_en = 1'b1; w_data = seq; seq = seq + 8'd1;
    end
    @(posedge wclk); #1;
    w_en = 1'b0;
  endtask

  task automatic take(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge rclk); #1;
      r_en = 1'b1;
    end
    @(posedge rclk); #1;
    r_en = 1'b0;
  endtask

  task automatic idle_checks(input string req);
    chk(w_level == '0, req, "w_level idle", int'(w_level), 0);
    chk(r_level == '0, req, "r_level idle", int'(r_level), 0);
    chk(r_rdy == 1'b0, req, "r_rdy idle", int'(r_rdy), 0);
    chk(w_rdy == 1'b1, req, "w_rdy idle", int'(w_rdy), 1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog (R1): got timeout expected completion");
    finish_run();
  end

  initial begin
    wrst = 1'b1; rrst = 1'b1; w_en = 1'b0; r_en = 1'b0; w_data = '0;
    repeat (12) @(posedge wclk); #1;
    wrst = 1'b0; rrst = 1'b0;
    settle();
    // Reset state (R7, R8)
    idle_checks("R7");
    chk(flag_seen, "R8", "r_rst_flag after power-up reset", int'(flag_seen), 1);
    chk(r_rst_flag == 1'b0, "R8", "r_rst_flag released", int'(r_rst_flag), 0);
    mon_on = 1'b1;

    // Fill past capacity: extra writes refused (R2), capacity rounded (R10)
    put(CAP + 4);
    settle();
    chk(int'(w_level) == CAP, "R10", "capacity from write side", int'(w_level), CAP);
    chk(int'(r_level) == CAP, "R6", "r_level settled full", int'(r_level), CAP);
    chk(w_rdy == 1'b0, "R4", "w_rdy at capacity", int'(w_rdy), 0);
    chk(model.size() == CAP, "R2", "accepted writes", model.size(), CAP);

    // Drain with extra reads on an empty queue (R3)
    take(CAP + 6);
    settle();
    chk(r_level == '0 && !r_rdy, "R3", "empty after drain", int'(r_level), 0);
    put(2);
    settle();
    chk(int'(r_level) == 2, "R3", "empty reads consumed nothing", int'(r_level), 2);
    take(3);
    settle();

    // Both strobes held at the full boundary (R1, R4, R5)
    put(CAP);
    settle();
    fork
      begin
        for (int i = 0; i < 60; i++) begin
          @(posedge wclk); #1; w_en = 1'b1; w_data = seq; seq = seq + 8'd1;
        end
        @(posedge wclk); #1; w_en = 1'b0;
      end
      begin
        for (int i = 0; i < 60; i++) begin
          @(posedge rclk); #1; r_en = 1'b1;
        end
        @(posedge rclk); #1; r_en = 1'b0;
      end
    join
    take(CAP + 12);
    settle();
    idle_checks("R6");

    // Random strobes on both sides (R1)
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          @(posedge wclk); #1; w_en = $urandom_range(0, 1) == 1;
          w_data = seq; seq = seq + 8'd1;
        end
        @(posedge wclk); #1; w_en = 1'b0;
      end
      begin
        for (int i = 0; i < 300; i++) begin
          @(posedge rclk); #1; r_en = $urandom_range(0, 2) != 0;
        end
        @(posedge rclk); #1; r_en = 1'b0;
      end
    join
    take(CAP + 12);
    settle();
    idle_checks("R6");

    // Read-side reset keeps entries (R9)
    put(5);
    settle();
    @(posedge rclk); #1; rrst = 1'b1;
    repeat (4) @(posedge rclk);
    #1; rrst = 1'b0;
    settle();
    chk(int'(r_level) == 5, "R9", "entries kept across rrst", int'(r_level), 5);
    take(8);
    settle();
    idle_checks("R9");

    // Write-side reset empties the queue (R7, R8)
    put(6);
    settle();
    mon_on = 1'b0;
    flag_seen = 1'b0;
    model.delete();
    @(posedge wclk); #1; wrst = 1'b1;
    repeat (8) @(posedge wclk);
    #1; wrst = 1'b0;
    settle();
    idle_checks("R7");
    chk(flag_seen, "R8", "r_rst_flag after write reset", int'(flag_seen), 1);
    mon_on = 1'b1;
    put(3);
    settle();
    chk(int'(r_level) == 3, "R7", "operation after write reset", int'(r_level), 3);
    take(5);
    settle();
    idle_checks("R6");

    finish_run();
  end
endmodule